// File: doc/BRIEF.md
# Modulated UART Receive Bit Timer

This block paces the receive side of an asynchronous serial port. The divider `ubr` and an 8-bit modulation pattern `mod` set the bit timing. Each bit period is `ubr` clocks, plus one more clock when the modulation bit for that position is set. Spreading those extra clocks over a frame gets close to a fractional baud divisor without a fractional counter.

The receive line first passes through a two-flop synchronizer. When the block is enabled and idle, a falling edge on that synchronized line starts a frame. The timer waits about half a period to reach the centre of the start bit, then one modulated period to reach the centre of each later bit. At every centre it takes a majority of three line samples and gives out a one-cycle strobe, the voted value and the bit's position in the frame. If the start bit votes high, the edge is treated as noise and the timer returns to idle. After `nbits` bits following the start bit, the frame is over. `nbits` counts data, parity and stop bits together.

Top module: `uart_rx_bit_timer`

## Requirements
- R1: `rxd` passes through two flops before edge detection. `busy` rises after the third rising clock edge that samples `rxd` low, provided the block is idle and `en` is high.
- R2: The strobe for the start bit (index 0) is high exactly floor(`ubr`/2) + `mod[0]` cycles after `busy` rises.
- R3: For a later bit i (1 to `nbits`), the strobe is high exactly `ubr` + `mod[i mod 8]` cycles after the strobe of bit i-1.
- R4: Modulation bits are used least significant first, starting at the start bit. The pointer wraps from bit 7 back to bit 0, so bit 8 uses `mod[0]` again. Every new frame restarts the pointer at `mod[0]`.
- R5: Each bit value is the majority of the synchronized line at the sample point and on the two cycles before it. A one-cycle disturbance of `rxd` inside that window does not change the result.
- R6: `sample_strobe` is a single-cycle pulse one cycle after each sample point. During that pulse, `bit_value` holds the voted value and `bit_index` holds the bit position: 0 for the start bit, then 1 to `nbits`.
- R7: If the start bit votes 1, no strobe is given, `busy` falls on the next cycle, and the timer waits for a new falling edge.
- R8: `bit_index` never exceeds `nbits`. `busy` falls in the same cycle as the strobe of bit `nbits`.
- R9: While `en` is low, the timer is idle from the next cycle on. It gives no strobes and ignores falling edges.
- R10: After reset, `busy`, `sample_strobe` and `bit_index` are 0.
- R11: The smallest legal divider is 3. At `ubr` = 3 the start interval is 1 or 2 cycles, and the timing of R2 and R3 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low forces idle |
| rxd | input | 1 | Asynchronous serial receive line |
| ubr | input | 16 | Integer bit-period divider, at least 3 |
| mod | input | 8 | Modulation pattern, bit 0 used first |
| nbits | input | 4 | Number of bits after the start bit |
| sample_strobe | output | 1 | One-cycle pulse per voted bit |
| bit_value | output | 1 | Majority-voted bit value |
| bit_index | output | 4 | Position of the voted bit, 0 is the start bit |
| busy | output | 1 | Frame timing in progress |

## Verification
On every cycle, the assertions check these rules:
- a strobe only follows a busy cycle and never lasts two cycles;
- a start-bit strobe always carries 0;
- the index stays within `nbits`;
- a low `en` empties the timer.

The exact number of cycles to each sample point needs the bench's scenarios, because it depends on the modulation bit chosen for each position. The same is true of LSB-first use of the pattern, its wrap on frames longer than eight bits, glitch rejection on the start bit and the majority outcome under one-cycle disturbances. The bench sweeps several dividers, patterns and frame lengths against a timeline computed from these rules.

// File: rtl/rxbt_pkg.sv
package rxbt_pkg;
  typedef enum logic {
    RX_IDLE   = 1'b0,
    RX_TIMING = 1'b1
  } rxbt_state_e;
endpackage

// File: rtl/rxbt_sync_edge.sv
module rxbt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign dout = chain_q[STAGES-1];
  assign fall = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rxbt_vote3.sv
module rxbt_vote3 (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic maj
);
  logic [1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 2'b11;
    else        hist_q <= {hist_q[0], din};
  end

  // din is the sample on the sample point, hist_q the two before it
  assign maj = (hist_q[1] & hist_q[0]) | (hist_q[1] & din) | (hist_q[0] & din);
endmodule

// File: rtl/rxbt_interval.sv
module rxbt_interval #(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8,
  parameter int PTR_W = 3
) (
  input  logic [DIV_W-1:0] divisor,
  input  logic [MOD_W-1:0] pattern,
  input  logic [PTR_W-1:0] ptr,
  input  logic             half,
  output logic [DIV_W:0]   reload
);
  localparam logic [DIV_W:0] ONE = {{DIV_W{1'b0}}, 1'b1};

  logic [DIV_W:0] base;
  logic [DIV_W:0] extra;

  always_comb begin
    base   = half ? {2'b00, divisor[DIV_W-1:1]} : {1'b0, divisor};
    extra  = {{DIV_W{1'b0}}, pattern[ptr]};
    // counter counts down to zero, so the load is one less than the interval
    reload = base + extra - ONE;
  end
endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer
  import rxbt_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int MOD_W       = 8,
  parameter int NB_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rxd,
  input  logic [DIV_W-1:0] ubr,
  input  logic [MOD_W-1:0] mod,
  input  logic [NB_W-1:0]  nbits,
  output logic             sample_strobe,
  output logic             bit_value,
  output logic [NB_W-1:0]  bit_index,
  output logic             busy
);
  localparam int CNT_W = DIV_W + 1;
  localparam int PTR_W = (MOD_W > 1) ? $clog2(MOD_W) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MOD_W - 1);

  rxbt_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [NB_W-1:0]  idx_q, idx_d;
  logic             strobe_q, strobe_d;
  logic             value_q, value_d;
  logic [NB_W-1:0]  index_q, index_d;

  logic             line_sync;
  logic             line_fall;
  logic             vote;
  logic             at_point;
  logic             sel_half;
  logic [PTR_W-1:0] sel_ptr;
  logic [CNT_W-1:0] reload;
  logic [PTR_W-1:0] ptr_inc;

  rxbt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_sync),
    .fall (line_fall)
  );

  rxbt_vote3 u_vote (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_sync),
    .maj  (vote)
  );

  rxbt_interval #(.DIV_W(DIV_W), .MOD_W(MOD_W), .PTR_W(PTR_W)) u_interval (
    .divisor(ubr),
    .pattern(mod),
    .ptr    (sel_ptr),
    .half   (sel_half),
    .reload (reload)
  );

  always_comb begin
    sel_half = (state_q == RX_IDLE);
    sel_ptr  = (state_q == RX_IDLE) ? '0 : ptr_q;
    ptr_inc  = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    at_point = (state_q == RX_TIMING) && (cnt_q == '0);
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    ptr_d    = ptr_q;
    idx_d    = idx_q;
    strobe_d = 1'b0;
    value_d  = value_q;
    index_d  = index_q;
    if (!en) begin
      state_d = RX_IDLE;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (line_fall) begin
            state_d = RX_TIMING;
            cnt_d   = reload;
            ptr_d   = (MOD_W > 1) ? PTR_W'(1) : '0;
            idx_d   = '0;
          end
        end
        RX_TIMING: begin
          if (!at_point) begin
            cnt_d = cnt_q - 1'b1;
          end else if ((idx_q == '0) && vote) begin
            state_d = RX_IDLE;
          end else begin
            strobe_d = 1'b1;
            value_d  = vote;
            index_d  = idx_q;
            if (idx_q == nbits) begin
              state_d = RX_IDLE;
            end else begin
              idx_d = idx_q + 1'b1;
              cnt_d = reload;
              ptr_d = ptr_inc;
            end
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      ptr_q    <= '0;
      idx_q    <= '0;
      strobe_q <= 1'b0;
      value_q  <= 1'b0;
      index_q  <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      ptr_q    <= ptr_d;
      idx_q    <= idx_d;
      strobe_q <= strobe_d;
      value_q  <= value_d;
      index_q  <= index_d;
    end
  end

  assign sample_strobe = strobe_q;
  assign bit_value     = value_q;
  assign bit_index     = index_q;
  assign busy          = (state_q == RX_TIMING);
endmodule

// File: rtl/uart_rx_bit_timer_chk.sv
module uart_rx_bit_timer_chk #(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8,
  parameter int NB_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [DIV_W-1:0] ubr,
  input logic [NB_W-1:0]  nbits,
  input logic             sample_strobe,
  input logic             bit_value,
  input logic [NB_W-1:0]  bit_index,
  input logic             busy
);
  localparam logic [DIV_W-1:0] UBR_MIN = DIV_W'(3);

  AST_STROBE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> $past(busy)); // R6

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && (ubr >= UBR_MIN)) |=> !sample_strobe); // R6

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && (bit_index == '0)) |-> !bit_value); // R7

  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> (bit_index <= nbits)); // R8

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !sample_strobe)); // R9
endmodule

bind uart_rx_bit_timer uart_rx_bit_timer_chk #(
  .DIV_W(DIV_W), .MOD_W(MOD_W), .NB_W(NB_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .ubr          (ubr),
  .nbits        (nbits),
  .sample_strobe(sample_strobe),
  .bit_value    (bit_value),
  .bit_index    (bit_index),
  .busy         (busy)
);

// File: tb/uart_rx_bit_timer_test.sv
module uart_rx_bit_timer_test;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic        rxd;
  logic [15:0] ubr;
  logic [7:0]  mod;
  logic [3:0]  nbits;
  logic        sample_strobe;
  logic        bit_value;
  logic [3:0]  bit_index;
  logic        busy;

  int checks = 0;
  int errors = 0;

  uart_rx_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .en(en), .rxd(rxd), .ubr(ubr), .mod(mod),
    .nbits(nbits), .sample_strobe(sample_strobe), .bit_value(bit_value),
    .bit_index(bit_index), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // mode: 0 normal, 1 en low for whole frame, 2 en dropped at abort_k
  task automatic run_frame(input int u, input logic [7:0] m, input int nb,
                           input logic [15:0] data, input bit glitch,
                           input int mode, input int abort_k);
    int p [0:15];
    int last;
    ubr = 16'(u); mod = m; nbits = 4'(nb);
    if (mode == 1) en = 1'b0;
    p[0] = u / 2 + int'(m[0]);
    for (int j = 1; j <= nb; j++) p[j] = p[j-1] + u + int'(m[j % 8]);
    last = p[nb];
    for (int k = 0; k <= last + 6; k++) begin
      bit exp_s, exp_b, exp_v, drv;
      int exp_i;
      string ttag;
      @(negedge clk);
      exp_s = 1'b0; exp_i = 0; exp_v = 1'b0;
      for (int j = 0; j <= nb; j++) begin
        if (k == p[j] + 3) begin
          exp_s = 1'b1; exp_i = j;
          exp_v = (j == 0) ? 1'b0 : data[j-1];
        end
      end
      exp_b = (k >= 3) && (k <= last + 2);
      if (mode == 1) begin exp_s = 1'b0; exp_b = 1'b0; end
      if (mode == 2 && k > abort_k) begin exp_s = 1'b0; exp_b = 1'b0; end
      if (mode != 0) ttag = "R9";
      else if (k == last + 3) ttag = "R8";
      else ttag = "R1";
      chk(busy === exp_b, ttag, int'(busy), int'(exp_b));
      if (mode != 0) ttag = "R9";
      else if (u == 3) ttag = "R11";
      else if (exp_i == 0) ttag = "R2";
      else if (exp_i >= 8) ttag = "R4";
      else ttag = "R3";
      chk(sample_strobe === exp_s, ttag, int'(sample_strobe), int'(exp_s));
      if (exp_s) begin
        chk(bit_index === 4'(exp_i), "R6", int'(bit_index), exp_i);
        chk(bit_value === exp_v, glitch ? "R5" : "R6", int'(bit_value), int'(exp_v));
      end
      if (k > last) drv = 1'b1;
      else if (k <= p[0]) drv = 1'b0;
      else begin
        drv = 1'b1;
        for (int j = 1; j <= nb; j++) begin
          if (k > p[j-1] && k <= p[j]) begin
            drv = data[j-1];
            if (glitch && k == p[j] - 1) drv = ~drv;
          end
        end
      end
      rxd = drv;
      if (mode == 2 && k == abort_k) en = 1'b0;
    end
    en = 1'b1;
    rxd = 1'b1;
  endtask

  // one-cycle low pulse on rxd: start vote must reject it
  task automatic run_start_glitch;
    ubr = 16'd8; mod = 8'h00; nbits = 4'd8;
    for (int k = 0; k <= 14; k++) begin
      @(negedge clk);
      if (k == 3) chk(busy === 1'b1, "R7", int'(busy), 1);
      if (k == 8) chk(busy === 1'b0, "R7", int'(busy), 0);
      chk(sample_strobe === 1'b0, "R7", int'(sample_strobe), 0);
      rxd = (k == 0) ? 1'b0 : 1'b1;
    end
  endtask

  initial begin
    int ulist [0:4];
    logic [7:0] mlist [0:3];
    int nlist [0:2];
    ulist = '{3, 4, 5, 13, 16};
    mlist = '{8'h00, 8'h6B, 8'hFF, 8'hA5};
    nlist = '{1, 8, 10};
    rst_n = 1'b0; en = 1'b1; rxd = 1'b1;
    ubr = 16'd13; mod = 8'h6B; nbits = 4'd8;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R10", int'(busy), 0);
    chk(sample_strobe === 1'b0, "R10", int'(sample_strobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_index === 4'd0, "R10", int'(bit_index), 0);
    chk(busy === 1'b0, "R10", int'(busy), 0);
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 3; c++)
          run_frame(ulist[a], mlist[b], nlist[c],
                    16'((ulist[a] * 977 + b * 313 + c * 71) ^ 16'h5A3C),
                    b[0], 0, 0);
    run_start_glitch();
    run_frame(13, 8'h6B, 8, 16'h00B5, 1'b0, 0, 0);
    run_frame(5, 8'h6B, 8, 16'h0055, 1'b0, 1, 0);
    run_frame(13, 8'h6B, 8, 16'h00C3, 1'b0, 2, 39);
    run_frame(13, 8'h6B, 15, 16'h3C96, 1'b1, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule